// File: doc/BRIEF.md
# Direct-Mapped Write-Through Cache

A single-level data cache placed between a processor and main memory. Each line stores one 32-bit word, a tag and a valid bit, and lines are selected by the address bits just above the byte offset. A read whose line is valid and whose tag matches is answered from the line without touching memory. A read that misses stalls the processor, fetches the word, installs it in the line and then returns it.

Every store is written into the indexed line, whether the line held that address or not. The line takes the new tag, the new data and the valid flag without any compare. The store then always goes out to memory, and the processor stays stalled until memory acknowledges it. At most one memory transaction is in flight at any time.

The processor holds `cpu_req`, `cpu_we`, `cpu_addr` and `cpu_wdata` steady until `cpu_ready` pulses, then drops or changes the request. The memory side holds `mem_req` and its fields steady until `mem_ack` pulses for one cycle.

Top module: `wtc_cache_top`

## Requirements
- R1: After reset, `cpu_ready` and `mem_req` are low and every line is invalid, so the first read of any address is a miss.
- R2: A read to a valid line with a matching tag returns the stored word with no memory request, and `cpu_ready` rises two clock edges after the request is first presented (counting the accepting edge).
- R3: A read miss issues exactly one memory request with `mem_we`=0 and `mem_addr` equal to the word address with bits [1:0] zero, returns `mem_rdata` on `cpu_rdata`, and fills the line so that a repeat read hits.
- R4: Every write, hit or miss, issues one memory request with `mem_we`=1, the word address and `cpu_wdata`, and `cpu_ready` does not rise before `mem_ack`.
- R5: A write installs its tag and data in the indexed line and marks it valid with no tag compare, so a later read of that address hits and returns the written word, and the line's previous address then misses.
- R6: Address bits [1:0] are ignored: addresses that differ only in those bits reach the same word.
- R7: With 3 index bits, reads of word addresses 22, 26, 22, 26, 16, 3, 16, 18 give miss, miss, hit, hit, miss, miss, hit, miss, and a following read of 26 misses because 18 replaced it in line 2.
- R8: `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stay stable while waiting for `mem_ack`, and `mem_req` falls the edge after an acknowledge, so one access causes at most one acknowledged transaction.
- R9: `cpu_ready` is high for exactly one cycle per access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor access request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address; bits [1:0] ignored |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, valid while `cpu_ready` is high |
| cpu_ready | output | 1 | One-cycle completion pulse; low means stalled |
| mem_req | output | 1 | Memory request, held until `mem_ack` |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 32 | Memory word address (bits [1:0] zero) |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |
| mem_ack | input | 1 | One-cycle memory acknowledge |

## Verification
The hardest situation to reach from the ports is a conflict: two addresses that share a line while the line holds the other one, especially when a write replaces a line that a read had filled. With 1024 lines, random addresses almost never collide. The bench therefore builds the cache with 3 index bits and draws word addresses from a 64-word window, so every line is fought over by eight tags. A shadow model of tags and valid bits predicts hit or miss for every access, and the presence of a memory request shows what the design actually did.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_FILL,
    ST_WRITE,
    ST_DONE
  } wtc_state_e;
endpackage

// File: rtl/wtc_tag_store.sv
module wtc_tag_store #(
  parameter int IDX_W = 10,
  parameter int TAG_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  output logic [TAG_W-1:0] rd_tag,
  output logic             rd_valid
);
  localparam int LINES = 1 << IDX_W;

  logic [TAG_W-1:0] tag_mem [LINES];
  logic [LINES-1:0] valid_bits;

  // Tag array: no reset, synchronous read, suitable for block RAM.
  always_ff @(posedge clk) begin
    if (wr_en) tag_mem[wr_idx] <= wr_tag;
    rd_tag <= tag_mem[rd_idx];
  end

  // Valid flags need a reset, so they live in flops.
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_bits <= '0;
      rd_valid   <= 1'b0;
    end else begin
      if (wr_en) valid_bits[wr_idx] <= 1'b1;
      rd_valid <= valid_bits[rd_idx];
    end
  end

  // R1: reset clears every valid flag.
  p_valid_clear_r1: assert property (@(posedge clk) rst |=> (valid_bits == '0));
  // R5: a write leaves its line valid.
  p_write_sets_valid_r5: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> valid_bits[$past(wr_idx)]);
endmodule

// File: rtl/wtc_data_store.sv
module wtc_data_store #(
  parameter int IDX_W  = 10,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);
  localparam int LINES = 1 << IDX_W;

  logic [DATA_W-1:0] word_mem [LINES];

  always_ff @(posedge clk) begin
    if (wr_en) word_mem[wr_idx] <= wr_data;
    rd_data <= word_mem[rd_idx];
  end
endmodule

// File: rtl/wtc_ctrl.sv
module wtc_ctrl
  import wtc_pkg::*;
#(
  parameter int IDX_W  = 10,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [31:0]       cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [31:0]       mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack,
  output logic [IDX_W-1:0]  rd_idx,
  input  logic [29-IDX_W:0] line_tag,
  input  logic              line_valid,
  input  logic [DATA_W-1:0] line_data,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [29-IDX_W:0] wr_tag,
  output logic [DATA_W-1:0] wr_data
);
  localparam int TAG_W = 30 - IDX_W;
  localparam int IDX_LO = 2;
  localparam int TAG_LO = IDX_LO + IDX_W;

  wtc_state_e        state;
  logic [TAG_W-1:0]  req_tag_q;
  logic [IDX_W-1:0]  req_idx_q;
  logic              req_we_q;
  logic [DATA_W-1:0] req_wdata_q;
  logic              hit;
  logic              unused_offset;

  assign unused_offset = ^cpu_addr[IDX_LO-1:0];

  // Array read is launched from the live address while idle.
  assign rd_idx = cpu_addr[TAG_LO-1:IDX_LO];
  assign hit    = line_valid && (line_tag == req_tag_q);

  // Line update: stores in lookup (no compare), fills on acknowledge.
  assign wr_en   = ((state == ST_LOOKUP) && req_we_q) ||
                   ((state == ST_FILL) && mem_ack);
  assign wr_idx  = req_idx_q;
  assign wr_tag  = req_tag_q;
  assign wr_data = (state == ST_FILL) ? mem_rdata : req_wdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      req_tag_q   <= '0;
      req_idx_q   <= '0;
      req_we_q    <= 1'b0;
      req_wdata_q <= '0;
      cpu_rdata   <= '0;
      cpu_ready   <= 1'b0;
      mem_req     <= 1'b0;
      mem_we      <= 1'b0;
      mem_addr    <= '0;
      mem_wdata   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          cpu_ready <= 1'b0;
          if (cpu_req) begin
            req_tag_q   <= cpu_addr[31:TAG_LO];
            req_idx_q   <= cpu_addr[TAG_LO-1:IDX_LO];
            req_we_q    <= cpu_we;
            req_wdata_q <= cpu_wdata;
            state       <= ST_LOOKUP;
          end
        end
        ST_LOOKUP: begin
          mem_addr  <= {req_tag_q, req_idx_q, 2'b00};
          mem_wdata <= req_wdata_q;
          if (req_we_q) begin
            mem_req <= 1'b1;
            mem_we  <= 1'b1;
            state   <= ST_WRITE;
          end else if (hit) begin
            cpu_rdata <= line_data;
            cpu_ready <= 1'b1;
            state     <= ST_DONE;
          end else begin
            mem_req <= 1'b1;
            mem_we  <= 1'b0;
            state   <= ST_FILL;
          end
        end
        ST_FILL: begin
          if (mem_ack) begin
            mem_req   <= 1'b0;
            cpu_rdata <= mem_rdata;
            cpu_ready <= 1'b1;
            state     <= ST_DONE;
          end
        end
        ST_WRITE: begin
          if (mem_ack) begin
            mem_req   <= 1'b0;
            cpu_ready <= 1'b1;
            state     <= ST_DONE;
          end
        end
        ST_DONE: begin
          cpu_ready <= 1'b0;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1: quiet outputs right after reset.
  p_quiet_after_reset_r1: assert property (@(posedge clk)
    rst |=> (!cpu_ready && !mem_req));
  // R8: request fields hold while waiting for the acknowledge.
  p_req_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) &&
                               $stable(mem_addr) && $stable(mem_wdata)));
  // R8: request drops after an acknowledge.
  p_req_drop_r8: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ack) |=> !mem_req);
  // R9: ready is a single-cycle pulse.
  p_ready_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |=> !cpu_ready);
  // R4: a pending store keeps a write request on the bus.
  p_store_on_bus_r4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WRITE) |-> (mem_req && mem_we));
  // R3: a fill is always a memory read.
  p_fill_is_read_r3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FILL) |-> (mem_req && !mem_we));
  // R4: ready never coincides with an outstanding request.
  p_no_early_ready_r4: assert property (@(posedge clk) disable iff (rst)
    !(cpu_ready && mem_req));
endmodule

// File: rtl/wtc_cache_top.sv
module wtc_cache_top #(
  parameter int IDX_W  = 10,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [31:0]       cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [31:0]       mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack
);
  localparam int TAG_W = 30 - IDX_W;

  logic [IDX_W-1:0]  rd_idx;
  logic [TAG_W-1:0]  line_tag;
  logic              line_valid;
  logic [DATA_W-1:0] line_data;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [TAG_W-1:0]  wr_tag;
  logic [DATA_W-1:0] wr_data;

  wtc_ctrl #(.IDX_W(IDX_W), .DATA_W(DATA_W)) ctrl_i (
    .clk(clk), .rst(rst),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .rd_idx(rd_idx), .line_tag(line_tag), .line_valid(line_valid),
    .line_data(line_data), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_tag(wr_tag), .wr_data(wr_data)
  );

  wtc_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) tags_i (
    .clk(clk), .rst(rst), .rd_idx(rd_idx), .wr_en(wr_en),
    .wr_idx(wr_idx), .wr_tag(wr_tag), .rd_tag(line_tag),
    .rd_valid(line_valid)
  );

  wtc_data_store #(.IDX_W(IDX_W), .DATA_W(DATA_W)) data_i (
    .clk(clk), .rd_idx(rd_idx), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_data(line_data)
  );
endmodule

// File: tb/wtc_cache_top_tb_top.sv
module wtc_cache_top_tb_top;
  localparam int IDX_W = 3;
  localparam int LINES = 1 << IDX_W;
  localparam int WORDS = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_req = 1'b0;
  logic        cpu_we = 1'b0;
  logic [31:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic        cpu_ready;
  logic        mem_req;
  logic        mem_we;
  logic [31:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        mem_ack = 1'b0;

  int checks = 0;
  int failures = 0;
  int ack_count = 0;
  int mem_delay = 0;

  logic [31:0] mem_model [WORDS];
  logic [31:0] exp_mem [WORDS];
  bit          sh_valid [LINES];
  int          sh_tag [LINES];

  // Result of the last access
  logic [31:0] got_rdata;
  bit          got_miss;
  int          got_edges;
  bit          got_mem_we;
  logic [31:0] got_mem_addr;
  logic [31:0] got_mem_wdata;
  int          got_acks;

  always #2 clk = ~clk;

  wtc_cache_top #(.IDX_W(IDX_W), .DATA_W(32)) dut_i (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_ready(cpu_ready), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ack(mem_ack)
  );

  function automatic logic [31:0] init_word(int w);
    return 32'hA500_0000 ^ (32'h0101_0101 * w);
  endfunction

  // Memory responder: random delay, one-cycle acknowledge.
  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 1'b0;
    end else if (mem_req && !rst) begin
      if (mem_delay > 0) begin
        mem_delay--;
      end else begin
        if (mem_we) mem_model[mem_addr[7:2]] = mem_wdata;
        else        mem_rdata = mem_model[mem_addr[7:2]];
        mem_ack = 1'b1;
        ack_count++;
        mem_delay = $urandom % 4;
      end
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(bit we, logic [31:0] addr, logic [31:0] wd);
    int start_acks;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
    got_miss = 1'b0; got_edges = 0; start_acks = ack_count;
    forever begin
      @(posedge clk);
      got_edges++;
      @(negedge clk);
      if (mem_req) begin
        got_miss = 1'b1; got_mem_we = mem_we;
        got_mem_addr = mem_addr; got_mem_wdata = mem_wdata;
      end
      if (cpu_ready) break;
      if (got_edges > 200) begin
        check("R9 access timeout", 32'd1, 32'd0);
        break;
      end
    end
    got_rdata = cpu_rdata;
    got_acks = ack_count - start_acks;
    cpu_req = 1'b0;
  endtask

  // Read with full prediction from the shadow model.
  task automatic do_read(int w, int off, string req);
    int ln = w % LINES;
    int tg = w / LINES;
    bit exp_miss = !(sh_valid[ln] && sh_tag[ln] == tg);
    access(1'b0, (w * 4) + off, 32'h0);
    check({req, " hit/miss"}, {31'd0, got_miss}, {31'd0, exp_miss});
    check({req, " read data"}, got_rdata, exp_mem[w]);
    if (exp_miss) begin
      check("R3 fill addr", got_mem_addr, w * 4);
      check("R3 fill is read", {31'd0, got_mem_we}, 32'd0);
      check("R8 one transaction", got_acks, 32'd1);
    end else begin
      check("R2 hit latency", got_edges, 32'd2);
      check("R2 no memory traffic", got_acks, 32'd0);
    end
    sh_valid[ln] = 1'b1; sh_tag[ln] = tg;
  endtask

  task automatic do_write(int w, int off, logic [31:0] d);
    access(1'b1, (w * 4) + off, d);
    check("R4 write goes to memory", {31'd0, got_miss}, 32'd1);
    check("R4 write strobe", {31'd0, got_mem_we}, 32'd1);
    check("R4 write addr", got_mem_addr, w * 4);
    check("R4 write data", got_mem_wdata, d);
    check("R8 one transaction", got_acks, 32'd1);
    exp_mem[w] = d;
    sh_valid[w % LINES] = 1'b1; sh_tag[w % LINES] = w / LINES;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check("watchdog", 32'd1, 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd20240611);
    for (int i = 0; i < WORDS; i++) begin
      mem_model[i] = init_word(i);
      exp_mem[i] = init_word(i);
    end
    for (int i = 0; i < LINES; i++) begin
      sh_valid[i] = 1'b0; sh_tag[i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: idle outputs after reset
    check("R1 ready low after reset", {31'd0, cpu_ready}, 32'd0);
    check("R1 mem_req low after reset", {31'd0, mem_req}, 32'd0);

    // R7: directed conflict pattern (R1: first touch misses)
    begin
      int seq [8] = '{22, 26, 22, 26, 16, 3, 16, 18};
      bit exp [8] = '{1, 1, 0, 0, 1, 1, 0, 1};
      for (int i = 0; i < 8; i++) begin
        access(1'b0, seq[i] * 4, 32'h0);
        check("R7 pattern miss", {31'd0, got_miss}, {31'd0, exp[i]});
        check("R7 pattern data", got_rdata, exp_mem[seq[i]]);
        sh_valid[seq[i] % LINES] = 1'b1; sh_tag[seq[i] % LINES] = seq[i] / LINES;
      end
      do_read(26, 0, "R7 evicted 26");
    end

    // R9: ready drops the cycle after it pulses
    @(negedge clk);
    check("R9 ready single cycle", {31'd0, cpu_ready}, 32'd0);

    // R6: byte offset ignored on a hit
    do_read(26, 3, "R6 offset 3");
    do_read(26, 1, "R6 offset 1");

    // R5: write to a line holding another tag, no compare
    do_write(34, 2, 32'hDEAD_BEEF);   // line 2 held 26
    do_read(34, 0, "R5 write allocated");
    do_read(26, 0, "R5 old tag evicted");
    // R4: write hit still goes to memory
    do_write(26, 0, 32'h1234_5678);
    do_read(26, 2, "R5 write hit data");

    // Random mix over a small window so lines conflict often (R2 R3 R4 R5 R6)
    for (int n = 0; n < 400; n++) begin
      int w = $urandom % WORDS;
      int off = $urandom % 4;
      if (($urandom % 3) == 0) do_write(w, off, $urandom);
      else do_read(w, off, "R3/R2 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule